// File: doc/BRIEF.md
# Sixteen-Bit ALU with Flag Generation

This block is the arithmetic and logic stage of a small RISC core. Each cycle in which `in_valid` is high it takes two operands, the incoming carry flag and an operation select. One clock later it presents the result, a write-back enable for the destination register, a flag-write enable, and the four condition flags: negative, overflow, zero and carry. Instruction fetch, the register file, memory access and the forming of immediates all belong to the surrounding core.

The operation select has two parts. A 3-bit class picks the unit: logic, add/subtract, test/compare, one-bit right shift or multiply. A 2-bit mode then picks the variant within that class. Compare and test use the subtractor and the AND path. They update the flags but never assert write-back. The shift fills the vacated top bit either with the old sign bit or with the incoming carry. The multiply returns either half of the full unsigned product. The interrupt-enable bit of the core's flag word is never produced or altered here.

Top module: `alu16_core`

## Requirements
- R1: After `rst_n` is deasserted and before any operation, `out_valid`, `wb_en`, `flag_we`, `result` and `flags` are all zero.
- R2: An operation accepted on a clock edge with `in_valid` high appears on the outputs after that same edge, with `out_valid` high. With `in_valid` low, the next outputs have `out_valid`, `wb_en` and `flag_we` low.
- R3: Class 3'b000 (logic) gives the result A&B for mode 00, A|B for 01, A^B for 10, and B for 11 (move). Write-back and flag write are both high.
- R4: Class 3'b001 (arithmetic) gives A+B for mode 00, A−B for 01, A+B+carry_in for 10, and A−B−carry_in for 11. Write-back and flag write are both high.
- R5: For add, flag bit 0 (carry) is the carry out of bit 15. For subtract, it is set when a borrow occurs. Flag bit 2 (overflow) is set on two's-complement overflow.
- R6: Class 3'b010 (test) with mode bit 0 = 0 computes A&B, and with mode bit 0 = 1 computes A−B with no carry in. The value appears on `result` and the flags follow from it, but `wb_en` stays low while `flag_we` is high.
- R7: Class 3'b011 (shift) shifts A right by one and moves A[0] into carry. The new bit 15 is A[15] when mode bit 0 = 0 and carry_in when mode bit 0 = 1. Overflow is cleared.
- R8: Class 3'b100 (multiply) returns bits 15:0 of the unsigned product A*B when mode bit 0 = 0, and bits 31:16 when mode bit 0 = 1.
- R9: Flag bit 1 (zero) is set exactly when the 16-bit result is zero, and flag bit 3 (negative) equals result bit 15. This holds for every class 0 to 4, including move.
- R10: Logic, move and multiply clear the overflow and carry flags, whatever carry_in is.
- R11: Classes 3'b101 to 3'b111 produce a zero result and zero flags, with `wb_en` and `flag_we` low, but `out_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_class | input | 3 | Unit select |
| op_mode | input | 2 | Variant within the class |
| opa | input | 16 | First operand (A) |
| opb | input | 16 | Second operand (B) |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Outputs hold a completed operation |
| wb_en | output | 1 | Write result to destination register |
| flag_we | output | 1 | Write flags to the flag word |
| result | output | 16 | Operation result |
| flags | output | 4 | {negative, overflow, zero, carry} |

## Verification
In a compare or test, the flag update and the suppression of write-back land in the same output cycle. That cycle also carries a result that must stay correct for the flags to be right. The bench issues compares whose difference is zero, negative with a borrow, and a plain test whose AND is zero. It places them directly after subtracts with identical operands. It then judges `result`, `flags`, `wb_en` low and `flag_we` high together. A second pairing is the shift with carry fill: carry_in is consumed as the new top bit in the same cycle that A[0] becomes the new carry, and the bench checks both directions of that exchange.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam logic [2:0] CLS_LOGIC = 3'd0;
    localparam logic [2:0] CLS_ARITH = 3'd1;
    localparam logic [2:0] CLS_TEST  = 3'd2;
    localparam logic [2:0] CLS_SHIFT = 3'd3;
    localparam logic [2:0] CLS_MULT  = 3'd4;

    localparam logic [1:0] LG_AND = 2'd0;
    localparam logic [1:0] LG_OR  = 2'd1;
    localparam logic [1:0] LG_XOR = 2'd2;
    localparam logic [1:0] LG_MOV = 2'd3;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/alu16_logic.sv
module alu16_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] y
);
    import alu16_pkg::*;

    always_comb begin
        unique case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = b;
        endcase
    end
endmodule

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         subtract,
    input  logic         use_carry,
    output logic [W-1:0] y,
    output logic         cout,
    output logic         ovf
);
    localparam int XW = W + 1;

    logic [XW-1:0] full;
    logic [XW-1:0] cext;

    always_comb begin
        cext = {{W{1'b0}}, (use_carry & cin)};
        if (subtract) begin
            full = {1'b0, a} - {1'b0, b} - cext;
        end else begin
            full = {1'b0, a} + {1'b0, b} + cext;
        end
        y    = full[W-1:0];
        cout = full[W];
        if (subtract) begin
            ovf = (a[W-1] != b[W-1]) && (y[W-1] != a[W-1]);
        end else begin
            ovf = (a[W-1] == b[W-1]) && (y[W-1] != a[W-1]);
        end
    end
endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  logic         fill_carry,
    output logic [W-1:0] y,
    output logic         cout
);
    logic top_bit;

    always_comb begin
        top_bit = fill_carry ? cin : a[W-1];
        y       = {top_bit, a[W-1:1]};
        cout    = a[0];
    end
endmodule

// File: rtl/alu16_mult.sv
module alu16_mult #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         upper,
    output logic [W-1:0] y
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;

    always_comb begin
        prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        y    = upper ? prod[PW-1:W] : prod[W-1:0];
    end
endmodule

// File: rtl/alu16_core.sv
module alu16_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [2:0]   op_class,
    input  logic [1:0]   op_mode,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         carry_in,
    output logic         out_valid,
    output logic         wb_en,
    output logic         flag_we,
    output logic [W-1:0] result,
    output logic [3:0]   flags
);
    import alu16_pkg::*;

    typedef struct packed {
        logic         vld;
        logic         wb;
        logic         fwe;
        logic [W-1:0] res;
        flags_t       fl;
    } out_t;

    out_t st_d, st_q;

    logic [1:0]   lg_sel;
    logic [W-1:0] lg_y;
    logic         as_sub, as_usec;
    logic [W-1:0] as_y;
    logic         as_co, as_ov;
    logic [W-1:0] sh_y;
    logic         sh_co;
    logic [W-1:0] mu_y;

    always_comb begin
        lg_sel  = (op_class == CLS_TEST) ? LG_AND : op_mode;
        as_sub  = (op_class == CLS_ARITH) ? op_mode[0] : 1'b1;
        as_usec = (op_class == CLS_ARITH) ? op_mode[1] : 1'b0;
    end

    alu16_logic #(.W(W)) u_logic (
        .a(opa), .b(opb), .sel(lg_sel), .y(lg_y)
    );

    alu16_addsub #(.W(W)) u_addsub (
        .a(opa), .b(opb), .cin(carry_in), .subtract(as_sub),
        .use_carry(as_usec), .y(as_y), .cout(as_co), .ovf(as_ov)
    );

    alu16_shift #(.W(W)) u_shift (
        .a(opa), .cin(carry_in), .fill_carry(op_mode[0]),
        .y(sh_y), .cout(sh_co)
    );

    alu16_mult #(.W(W)) u_mult (
        .a(opa), .b(opb), .upper(op_mode[0]), .y(mu_y)
    );

    always_comb begin
        st_d     = '0;
        st_d.vld = in_valid;
        if (in_valid) begin
            unique case (op_class)
                CLS_LOGIC: begin
                    st_d.res = lg_y;
                    st_d.wb  = 1'b1;
                    st_d.fwe = 1'b1;
                end
                CLS_ARITH: begin
                    st_d.res  = as_y;
                    st_d.fl.c = as_co;
                    st_d.fl.v = as_ov;
                    st_d.wb   = 1'b1;
                    st_d.fwe  = 1'b1;
                end
                CLS_TEST: begin
                    if (op_mode[0]) begin
                        st_d.res  = as_y;
                        st_d.fl.c = as_co;
                        st_d.fl.v = as_ov;
                    end else begin
                        st_d.res = lg_y;
                    end
                    st_d.fwe = 1'b1;
                end
                CLS_SHIFT: begin
                    st_d.res  = sh_y;
                    st_d.fl.c = sh_co;
                    st_d.wb   = 1'b1;
                    st_d.fwe  = 1'b1;
                end
                CLS_MULT: begin
                    st_d.res = mu_y;
                    st_d.wb  = 1'b1;
                    st_d.fwe = 1'b1;
                end
                default: begin
                    st_d.res = '0;
                end
            endcase
            if (st_d.fwe) begin
                st_d.fl.z = (st_d.res == '0);
                st_d.fl.n = st_d.res[W-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign wb_en     = st_q.wb;
    assign flag_we   = st_q.fwe;
    assign result    = st_q.res;
    assign flags     = st_q.fl;

endmodule

// File: rtl/alu16_chk.sv
module alu16_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [2:0]   op_class,
    input logic [1:0]   op_mode,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         carry_in,
    input logic         out_valid,
    input logic         wb_en,
    input logic         flag_we,
    input logic [W-1:0] result,
    input logic [3:0]   flags
);
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wb_en && !flag_we)); // R2
    AST_MOVE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 3'd0 && op_mode == 2'd3) |=> (result == $past(opb))); // R3
    AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 3'd1 && op_mode == 2'd0)
        |=> ({flags[0], result} == ({1'b0, $past(opa)} + {1'b0, $past(opb)}))); // R5
    AST_TEST_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 3'd2) |=> (!wb_en && flag_we)); // R6
    AST_SHIFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 3'd3) |=> (flags[0] == $past(opa[0]) && !flags[2])); // R7
    AST_ZERO_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (flags[1] == (result == '0) && flags[3] == result[W-1])); // R9
    AST_CLEAR_VC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_class == 3'd0 || op_class == 3'd4)) |=> (flags[2:0] == {1'b0, flags[1], 1'b0})); // R10
    AST_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class > 3'd4) |=> (!wb_en && !flag_we && result == '0)); // R11
endmodule

bind alu16_core alu16_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
    .op_mode(op_mode), .opa(opa), .opb(opb), .carry_in(carry_in),
    .out_valid(out_valid), .wb_en(wb_en), .flag_we(flag_we),
    .result(result), .flags(flags)
);

// File: tb/alu16_core_test.sv
module alu16_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 23;

    // {class[3], mode[2], cin, a[16], b[16], exp_res[16], exp_wb, exp_fwe, exp_flags[4] NVZC}
    localparam logic [59:0] VEC [NVEC] = '{
        {3'd0, 2'd0, 1'b1, 16'hF0F0, 16'h0FF0, 16'h00F0, 1'b1, 1'b1, 4'h0}, // R3 AND, R10
        {3'd0, 2'd1, 1'b0, 16'h8000, 16'h0001, 16'h8001, 1'b1, 1'b1, 4'h8}, // R3 OR, R9
        {3'd0, 2'd2, 1'b0, 16'h1234, 16'h1234, 16'h0000, 1'b1, 1'b1, 4'h2}, // R3 XOR, R9
        {3'd0, 2'd3, 1'b1, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b1, 4'h2}, // R3 MOV, R9, R10
        {3'd1, 2'd0, 1'b1, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 1'b1, 4'hC}, // R4 ADD, R5 overflow
        {3'd1, 2'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b1, 4'h3}, // R5 carry out
        {3'd1, 2'd1, 1'b0, 16'h0001, 16'h0002, 16'hFFFF, 1'b1, 1'b1, 4'h9}, // R5 borrow
        {3'd1, 2'd1, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 1'b1, 1'b1, 4'h4}, // R5 sub overflow
        {3'd1, 2'd2, 1'b1, 16'h0001, 16'h0001, 16'h0003, 1'b1, 1'b1, 4'h0}, // R4 ADC
        {3'd1, 2'd2, 1'b1, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 1'b1, 4'h3}, // R4 ADC wrap
        {3'd1, 2'd3, 1'b1, 16'h0005, 16'h0003, 16'h0001, 1'b1, 1'b1, 4'h0}, // R4 SBC
        {3'd1, 2'd3, 1'b1, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, 1'b1, 4'h9}, // R4 SBC borrow
        {3'd1, 2'd1, 1'b0, 16'h0005, 16'h0005, 16'h0000, 1'b1, 1'b1, 4'h2}, // R4 SUB before CMP
        {3'd2, 2'd1, 1'b1, 16'h0005, 16'h0005, 16'h0000, 1'b0, 1'b1, 4'h2}, // R6 CMP equal
        {3'd2, 2'd1, 1'b0, 16'h0003, 16'h0005, 16'hFFFE, 1'b0, 1'b1, 4'h9}, // R6 CMP borrow
        {3'd2, 2'd0, 1'b1, 16'h00FF, 16'hFF00, 16'h0000, 1'b0, 1'b1, 4'h2}, // R6 TST
        {3'd3, 2'd0, 1'b0, 16'h8003, 16'h0000, 16'hC001, 1'b1, 1'b1, 4'h9}, // R7 sign fill
        {3'd3, 2'd1, 1'b0, 16'h8002, 16'h0000, 16'h4001, 1'b1, 1'b1, 4'h0}, // R7 carry fill 0
        {3'd3, 2'd1, 1'b1, 16'h0001, 16'h0000, 16'h8000, 1'b1, 1'b1, 4'h9}, // R7 carry fill 1
        {3'd4, 2'd0, 1'b1, 16'h0100, 16'h0100, 16'h0000, 1'b1, 1'b1, 4'h2}, // R8 low, R10
        {3'd4, 2'd1, 1'b0, 16'h0100, 16'h0100, 16'h0001, 1'b1, 1'b1, 4'h0}, // R8 high
        {3'd4, 2'd1, 1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFE, 1'b1, 1'b1, 4'h8}, // R8 high max
        {3'd5, 2'd3, 1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 4'h0}  // R11 reserved
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_class = '0;
    logic [1:0]  op_mode = '0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic        carry_in = 1'b0;
    logic        out_valid, wb_en, flag_we;
    logic [15:0] result;
    logic [3:0]  flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu16_core uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
        .op_mode(op_mode), .opa(opa), .opb(opb), .carry_in(carry_in),
        .out_valid(out_valid), .wb_en(wb_en), .flag_we(flag_we),
        .result(result), .flags(flags)
    );

    task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {out_valid, wb_en, flag_we, result, flags}, 23'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: idle after reset
        check("R2 idle", {out_valid, wb_en, flag_we, result, flags}, 23'h0);

        for (int i = 0; i < NVEC; i++) begin
            {op_class, op_mode, carry_in, opa, opb} = VEC[i][59:22];
            in_valid = 1'b1;
            @(negedge clk);
            check($sformatf("vector %0d R2-R11 table", i),
                  {out_valid, wb_en, flag_we, result, flags},
                  {1'b1, VEC[i][5:4], VEC[i][21:6], VEC[i][3:0]});
        end

        // R2: dropping in_valid clears valid and enables next cycle
        in_valid = 1'b0;
        op_class = 3'd1;
        @(negedge clk);
        check("R2 drop", {out_valid, wb_en, flag_we, 20'h0}, 23'h0);

        // R6: compare with negative overflow, no write-back
        {in_valid, op_class, op_mode, carry_in, opa, opb} = {1'b1, 3'd2, 2'd3, 1'b1, 16'h8000, 16'h0001};
        @(negedge clk);
        check("R6 cmp ovf", {out_valid, wb_en, flag_we, result, flags},
              {1'b1, 1'b0, 1'b1, 16'h7FFF, 4'h4});

        // R7: arithmetic shift of positive value
        {op_class, op_mode, carry_in, opa} = {3'd3, 2'd2, 1'b1, 16'h0002};
        @(negedge clk);
        check("R7 asr pos", {out_valid, wb_en, flag_we, result, flags},
              {3'b111, 16'h0001, 4'h0});

        // R11: highest reserved class ignores operands
        {op_class, op_mode, opa, opb} = {3'd7, 2'd0, 16'h1111, 16'h2222};
        @(negedge clk);
        check("R11 class7", {out_valid, wb_en, flag_we, result, flags},
              {3'b100, 16'h0000, 4'h0});

        // R1: synchronous reset mid-stream clears outputs
        rst_n = 1'b0;
        {op_class, op_mode, opa, opb} = {3'd0, 2'd1, 16'hFFFF, 16'h0000};
        @(negedge clk);
        check("R1 reset", {out_valid, wb_en, flag_we, result, flags}, 23'h0);

        in_valid = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule